// File: doc/BRIEF.md
# Transmit Descriptor Queue Walker

This block feeds a transmit path from a linked list of four-word descriptors kept in system memory. The host writes a head pointer. The walker then reads each descriptor and presents its buffer address, routing word and message length to a transmit requester. When the transmit is acknowledged, it writes the updated status word back to memory and moves on to the next descriptor in the chain. Each descriptor is a whole message, so its start-of-message and end-of-message flags are both set.

The host and the walker hand descriptors back and forth through an ownership flag. After every status writeback the walker raises an interrupt. The host clears it by writing, to a completion-pointer port, the address of the last descriptor it has handled. The host can also ask for a teardown. The walker acts on it at the next descriptor boundary: it marks a descriptor with a teardown-complete flag, which tells the host that the channel's buffers may be reclaimed.

Memory traffic has one access outstanding at a time. A request is held until the memory answers with a single-cycle valid. For a read, the data arrives with that valid.

Top module: `txq_walker`

## Requirements
- R1: While reset is asserted and afterwards with no host stimulus, `irq`, `mem_req`, `tx_req` and `busy` are 0. A memory request and a transmit request are never active in the same cycle.
- R2: A `head_wr` pulse with a nonzero `head_ptr` while idle starts a walk at that byte address. A `head_wr` with `head_ptr` equal to 0 leaves the walker idle and issues no memory request.
- R3: A descriptor at byte address A is read as four words at A, A+4, A+8 and A+12. These are: next pointer, buffer address, routing word, and status word. The status word carries the message length in bits [15:0]. While `tx_req` is high, `tx_buf_addr`, `tx_route` and `tx_len` show these fields, and they hold until `tx_done`.
- R4: Status-word bit positions are: 31 start-of-message, 30 end-of-message, 29 ownership (1 = walker owns it), 28 end-of-queue, 27 teardown-complete. Bits 26..0 hold other fields. A writeback goes to A+12. It clears bit 29 and keeps bits 31, 30 and 26..0 unchanged.
- R5: The writeback sets bit 28 to 1 if the descriptor's next pointer is 0, and writes it as 0 otherwise. Bit 27 is written as 0.
- R6: After a writeback, the walker fetches the descriptor at the next pointer if that pointer is nonzero. If it is zero, the walker becomes idle.
- R7: If a fetched status word has bit 29 at 0, the walker becomes idle. It raises no transmit request and performs no memory write.
- R8: `irq` becomes 1 on the clock edge that completes a status writeback.
- R9: A `cp_wr` whose `cp_data` equals the address of the most recently written-back descriptor clears `irq` at the next edge. A `cp_wr` with any other value leaves `irq` at 1.
- R10: A `teardown_req` seen during a walk is honoured after the current writeback, and no further transmit is started. If the next pointer is nonzero, the walker reads that descriptor's status word, then writes it back with bit 29 cleared and bit 27 set. After that it becomes idle.
- R11: If a teardown is pending when the queue is empty, the walker reads the status word of the most recently written-back descriptor and rewrites it with bit 27 set and bit 29 cleared. This covers a request made while idle and a request that arrives during the last descriptor.
- R12: A memory request keeps `mem_req` high and holds `mem_addr` and `mem_we` stable until the cycle in which `mem_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_wr | input | 1 | Head pointer write strobe |
| head_ptr | input | 32 | Byte address of the first descriptor |
| teardown_req | input | 1 | Teardown command pulse |
| cp_wr | input | 1 | Completion pointer write strobe |
| cp_data | input | 32 | Completion pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_req | output | 1 | Transmit request |
| tx_buf_addr | output | 32 | Buffer address of the message |
| tx_route | output | 32 | Routing word of the message |
| tx_len | output | 16 | Message length |
| tx_done | input | 1 | Transmit finished |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Walker is not idle |

## Verification
Each memory access finishes on the edge where `mem_valid` is high. The bench memory raises `mem_valid` half a cycle after it sees a request, so each read or write takes two cycles. The scoreboard compares a write's address and data at the falling edge where the memory model accepts it. It compares transmit fields at the first falling edge after `tx_req` rises. `irq` settles one edge after the writeback's valid cycle, and it clears one edge after a matching `cp_wr`. The bench therefore checks `irq` at the falling edge after the walker has gone idle, and at the falling edge that follows each completion-pointer strobe. Stimulus that should change nothing (a zero head pointer, a descriptor the host still owns) is judged by an empty scoreboard, an unchanged memory word and a quiet `irq` once `busy` has dropped.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned ST_SOP = 31;
  localparam int unsigned ST_EOP = 30;
  localparam int unsigned ST_OWN = 29;
  localparam int unsigned ST_EOQ = 28;
  localparam int unsigned ST_TDC = 27;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_FETCH = 3'd1,
    W_XMIT  = 3'd2,
    W_WB    = 3'd3,
    W_TD_RD = 3'd4,
    W_TD_WR = 3'd5
  } walk_state_e;
endpackage

// File: rtl/txq_desc_regs.sv
module txq_desc_regs #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 4,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IW-1:0]    cap_idx,
  input  logic [DW-1:0]    cap_data,
  output logic [NW*DW-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          word_en;
    assign word_en = cap_en && (cap_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= cap_data;
    end
    assign words[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_done,
  input  logic [DW-1:0] wb_addr,
  input  logic          cp_wr,
  input  logic [DW-1:0] cp_data,
  output logic          irq,
  output logic [DW-1:0] last_addr,
  output logic          last_valid
);
  logic irq_n;

  always_comb begin
    irq_n = irq;
    if (wb_done)                             irq_n = 1'b1;
    else if (cp_wr && (cp_data == last_addr)) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      last_addr  <= '0;
      last_valid <= 1'b0;
    end else begin
      irq <= irq_n;
      if (wb_done) begin
        last_addr  <= wb_addr;
        last_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
  import txq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 4,
  localparam int unsigned IW = $clog2(NW),
  localparam int unsigned STAT_OFS = (NW - 1) * 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_wr,
  input  logic [DW-1:0] head_ptr,
  input  logic          teardown_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] next_ptr,
  input  logic [DW-1:0] stat_word,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx,
  output logic          tx_req,
  input  logic          tx_done,
  output logic          wb_done,
  output logic [DW-1:0] wb_addr,
  input  logic [DW-1:0] last_addr,
  input  logic          last_valid,
  output logic          busy
);
  walk_state_e   state, state_n;
  logic [DW-1:0] cur_q, cur_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          tdp_q, tdp_n;
  logic [DW-1:0] tda_q, tda_n;
  logic [DW-1:0] wb_word, td_word;
  logic [DW-1:0] fetch_addr;

  assign fetch_addr = cur_q + {{(DW-IW-2){1'b0}}, idx_q, 2'b00};
  assign wb_addr    = cur_q;
  assign busy       = (state != W_IDLE);

  always_comb begin
    wb_word         = stat_word;
    wb_word[ST_OWN] = 1'b0;
    wb_word[ST_EOQ] = (next_ptr == '0);
    wb_word[ST_TDC] = 1'b0;
    td_word         = stat_word;
    td_word[ST_OWN] = 1'b0;
    td_word[ST_TDC] = 1'b1;
  end

  always_comb begin
    state_n   = state;
    cur_n     = cur_q;
    idx_n     = idx_q;
    tdp_n     = tdp_q | teardown_req;
    tda_n     = tda_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    cap_en    = 1'b0;
    cap_idx   = idx_q;
    tx_req    = 1'b0;
    wb_done   = 1'b0;
    unique case (state)
      W_IDLE: begin
        if (head_wr && (head_ptr != '0)) begin
          cur_n   = head_ptr;
          idx_n   = '0;
          state_n = W_FETCH;
        end else if (tdp_n) begin
          if (last_valid) begin
            tda_n   = last_addr;
            state_n = W_TD_RD;
          end else begin
            tdp_n = 1'b0;
          end
        end
      end
      W_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = fetch_addr;
        if (mem_valid) begin
          cap_en = 1'b1;
          if (idx_q == IW'(NW - 1)) begin
            idx_n   = '0;
            state_n = mem_rdata[ST_OWN] ? W_XMIT : W_IDLE;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      W_XMIT: begin
        tx_req = 1'b1;
        if (tx_done) state_n = W_WB;
      end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + DW'(STAT_OFS);
        mem_wdata = wb_word;
        if (mem_valid) begin
          wb_done = 1'b1;
          if (tdp_n) begin
            tda_n   = (next_ptr != '0) ? next_ptr : cur_q;
            state_n = W_TD_RD;
          end else if (next_ptr != '0) begin
            cur_n   = next_ptr;
            state_n = W_FETCH;
          end else begin
            state_n = W_IDLE;
          end
        end
      end
      W_TD_RD: begin
        mem_req  = 1'b1;
        mem_addr = tda_q + DW'(STAT_OFS);
        if (mem_valid) begin
          cap_en  = 1'b1;
          cap_idx = IW'(NW - 1);
          state_n = W_TD_WR;
        end
      end
      W_TD_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tda_q + DW'(STAT_OFS);
        mem_wdata = td_word;
        if (mem_valid) begin
          tdp_n   = 1'b0;
          state_n = W_IDLE;
        end
      end
      default: state_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      cur_q <= '0;
      idx_q <= '0;
      tdp_q <= 1'b0;
      tda_q <= '0;
    end else begin
      state <= state_n;
      cur_q <= cur_n;
      idx_q <= idx_n;
      tdp_q <= tdp_n;
      tda_q <= tda_n;
    end
  end
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned LENW = 16,
  localparam int unsigned NW  = DESC_WORDS,
  localparam int unsigned IW  = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_wr,
  input  logic [DW-1:0]   head_ptr,
  input  logic            teardown_req,
  input  logic            cp_wr,
  input  logic [DW-1:0]   cp_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_valid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            tx_req,
  output logic [DW-1:0]   tx_buf_addr,
  output logic [DW-1:0]   tx_route,
  output logic [LENW-1:0] tx_len,
  input  logic            tx_done,
  output logic            irq,
  output logic            busy
);
  logic [NW*DW-1:0] words;
  logic             cap_en;
  logic [IW-1:0]    cap_idx;
  logic             wb_done;
  logic [DW-1:0]    wb_addr;
  logic [DW-1:0]    last_addr;
  logic             last_valid;
  logic [DW-1:0]    stat_word;

  assign stat_word   = words[(NW-1)*DW +: DW];
  assign tx_buf_addr = words[1*DW +: DW];
  assign tx_route    = words[2*DW +: DW];
  assign tx_len      = stat_word[LENW-1:0];

  txq_desc_regs #(.DW(DW), .NW(NW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rdata), .words(words)
  );

  txq_fsm #(.DW(DW), .NW(NW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_ptr(head_ptr),
    .teardown_req(teardown_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .next_ptr(words[0 +: DW]), .stat_word(stat_word),
    .cap_en(cap_en), .cap_idx(cap_idx), .tx_req(tx_req), .tx_done(tx_done),
    .wb_done(wb_done), .wb_addr(wb_addr), .last_addr(last_addr),
    .last_valid(last_valid), .busy(busy)
  );

  txq_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .wb_done(wb_done), .wb_addr(wb_addr),
    .cp_wr(cp_wr), .cp_data(cp_data), .irq(irq), .last_addr(last_addr),
    .last_valid(last_valid)
  );
endmodule

module txq_walker_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_valid,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          tx_req,
  input logic          tx_done,
  input logic [DW-1:0] tx_buf_addr,
  input logic          irq,
  input logic          cp_wr,
  input logic [DW-1:0] cp_data,
  input logic [DW-1:0] last_addr
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req && $stable(tx_buf_addr));
  assert_own_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[29]);
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_valid && mem_we));
  assert_irq_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && cp_wr && (cp_data != last_addr) |=> irq);
  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_req));
endmodule

bind txq_walker txq_walker_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_req(tx_req), .tx_done(tx_done), .tx_buf_addr(tx_buf_addr),
  .irq(irq), .cp_wr(cp_wr), .cp_data(cp_data), .last_addr(last_addr)
);

// File: tb/txq_walker_bench.sv
module txq_walker_bench;
  logic        clk;
  logic        rst_n;
  logic        head_wr, teardown_req, cp_wr;
  logic [31:0] head_ptr, cp_data;
  logic        mem_req, mem_we, mem_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_req, tx_done, irq, busy;
  logic [31:0] tx_buf_addr, tx_route;
  logic [15:0] tx_len;

  txq_walker u_txq_walker (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_ptr(head_ptr),
    .teardown_req(teardown_req), .cp_wr(cp_wr), .cp_data(cp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_route(tx_route),
    .tx_len(tx_len), .tx_done(tx_done), .irq(irq), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];
  string       exp_wt[$];
  logic [31:0] exp_tb[$];
  logic [31:0] exp_tr[$];
  logic [15:0] exp_tl[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory and transmit models plus scoreboard monitor
  int  tx_cnt;
  bit  tx_busy;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0; mem_rdata <= '0; tx_done <= 1'b0;
      tx_busy <= 1'b0; tx_cnt <= 0;
    end else begin
      if (mem_req && !mem_valid) begin
        mem_valid <= 1'b1;
        if (mem_we) begin
          if (exp_wa.size() == 0) begin
            chk(1'b0, "R7 unexpected write", mem_addr, 32'hx);
          end else begin
            string t;
            logic [31:0] ea, ed;
            ea = exp_wa.pop_front(); ed = exp_wd.pop_front(); t = exp_wt.pop_front();
            chk(mem_addr == ea, {t, " write address"}, mem_addr, ea);
            chk(mem_wdata == ed, {t, " write data"}, mem_wdata, ed);
          end
          mem[mem_addr[9:2]] <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
        end
      end else begin
        mem_valid <= 1'b0;
      end

      if (tx_done) begin
        tx_done <= 1'b0; tx_busy <= 1'b0;
      end else if (tx_req && !tx_busy) begin
        tx_busy <= 1'b1; tx_cnt <= 3;
        if (exp_tb.size() == 0) begin
          chk(1'b0, "R7 unexpected transmit", tx_buf_addr, 32'hx);
        end else begin
          logic [31:0] eb, er;
          logic [15:0] el;
          eb = exp_tb.pop_front(); er = exp_tr.pop_front(); el = exp_tl.pop_front();
          chk(tx_buf_addr == eb, "R3 buffer address", tx_buf_addr, eb);
          chk(tx_route == er, "R3 routing word", tx_route, er);
          chk(tx_len == el, "R3 length", {16'h0, tx_len}, {16'h0, el});
        end
      end else if (tx_busy) begin
        if (tx_cnt == 0) tx_done <= 1'b1;
        else tx_cnt <= tx_cnt - 1;
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] b,
                          input logic [31:0] r, input logic [15:0] len, input bit own);
    mem[a[9:2]]     = nxt;
    mem[a[9:2] + 1] = b;
    mem[a[9:2] + 2] = r;
    mem[a[9:2] + 3] = 32'hC0000000 | (32'(own) << 29) | (32'h5 << 20) | 32'(len);
  endtask

  task automatic expect_msg(input logic [31:0] a, input string tag);
    logic [31:0] st;
    st = mem[a[9:2] + 3];
    exp_tb.push_back(mem[a[9:2] + 1]);
    exp_tr.push_back(mem[a[9:2] + 2]);
    exp_tl.push_back(st[15:0]);
    st[29] = 1'b0;
    st[28] = (mem[a[9:2]] == 32'h0);
    st[27] = 1'b0;
    exp_wa.push_back(a + 12); exp_wd.push_back(st); exp_wt.push_back(tag);
  endtask

  task automatic expect_td(input logic [31:0] a, input logic [31:0] st_now, input string tag);
    logic [31:0] st;
    st = st_now; st[29] = 1'b0; st[27] = 1'b1;
    exp_wa.push_back(a + 12); exp_wd.push_back(st); exp_wt.push_back(tag);
  endtask

  task automatic start(input logic [31:0] p);
    @(negedge clk); head_wr = 1'b1; head_ptr = p;
    @(negedge clk); head_wr = 1'b0; head_ptr = '0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic write_cp(input logic [31:0] v);
    @(negedge clk); cp_wr = 1'b1; cp_data = v;
    @(negedge clk); cp_wr = 1'b0; cp_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=busy expected=idle");
    finish_run();
  end

  initial begin
    logic [31:0] kept;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; head_wr = 0; head_ptr = '0; teardown_req = 0; cp_wr = 0; cp_data = '0;
    repeat (3) @(negedge clk);
    chk(irq == 0 && mem_req == 0 && tx_req == 0 && busy == 0, "R1 in reset",
        {28'h0, irq, mem_req, tx_req, busy}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 0 && mem_req == 0 && tx_req == 0 && busy == 0, "R1 after reset",
        {28'h0, irq, mem_req, tx_req, busy}, 32'h0);

    // R2: zero head pointer is ignored
    start(32'h0);
    repeat (5) @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R2 zero head stays idle", {30'h0, busy, mem_req}, 32'h0);

    // R3 R4 R5 R6: three-descriptor chain
    put_desc(32'h040, 32'h080, 32'h1000_0001, 32'hA1A1_0001, 16'd64, 1);
    put_desc(32'h080, 32'h0C0, 32'h2000_0002, 32'hB2B2_0002, 16'd128, 1);
    put_desc(32'h0C0, 32'h000, 32'h3000_0003, 32'hC3C3_0003, 16'd7, 1);
    expect_msg(32'h040, "R4");
    expect_msg(32'h080, "R5 no eoq");
    expect_msg(32'h0C0, "R5 eoq on last");
    start(32'h040);
    wait_idle();
    chk(exp_wa.size() == 0 && exp_tb.size() == 0, "R6 chain fully walked",
        32'(exp_wa.size() + exp_tb.size()), 32'h0);
    chk(irq == 1'b1, "R8 irq after writeback", {31'h0, irq}, 32'h1);

    // R9: mismatching then matching completion pointer
    write_cp(32'h080);
    chk(irq == 1'b1, "R9 mismatch keeps irq", {31'h0, irq}, 32'h1);
    write_cp(32'h0C0);
    chk(irq == 1'b0, "R9 match clears irq", {31'h0, irq}, 32'h0);

    // R7: host-owned descriptor halts the walk
    put_desc(32'h200, 32'h040, 32'h4000_0004, 32'hD4D4_0004, 16'd9, 0);
    kept = mem[(32'h200 >> 2) + 3];
    start(32'h200);
    wait_idle();
    chk(mem[(32'h200 >> 2) + 3] == kept, "R7 status untouched", mem[(32'h200 >> 2) + 3], kept);
    chk(irq == 1'b0, "R7 no irq", {31'h0, irq}, 32'h0);

    // R10: teardown during first of two descriptors
    put_desc(32'h100, 32'h140, 32'h5000_0005, 32'hE5E5_0005, 16'd33, 1);
    put_desc(32'h140, 32'h000, 32'h6000_0006, 32'hF6F6_0006, 16'd44, 1);
    expect_msg(32'h100, "R10 first writeback");
    expect_td(32'h140, mem[(32'h140 >> 2) + 3], "R10 teardown mark");
    start(32'h100);
    while (!tx_req) @(negedge clk);
    teardown_req = 1'b1;
    @(negedge clk); teardown_req = 1'b0;
    wait_idle();
    chk(exp_wa.size() == 0 && exp_tb.size() == 0, "R10 no second transmit",
        32'(exp_wa.size() + exp_tb.size()), 32'h0);
    write_cp(32'h100);
    chk(irq == 1'b0, "R9 clear after teardown run", {31'h0, irq}, 32'h0);

    // R11: teardown while idle marks last processed descriptor
    expect_td(32'h100, mem[(32'h100 >> 2) + 3], "R11 idle teardown");
    @(negedge clk); teardown_req = 1'b1;
    @(negedge clk); teardown_req = 1'b0;
    wait_idle();
    chk(exp_wa.size() == 0, "R11 mark written", 32'(exp_wa.size()), 32'h0);

    // R11: teardown arriving during the last descriptor of a queue
    put_desc(32'h180, 32'h000, 32'h7000_0007, 32'h1717_0007, 16'd5, 1);
    expect_msg(32'h180, "R11 last writeback");
    begin
      logic [31:0] s;
      s = mem[(32'h180 >> 2) + 3]; s[29] = 0; s[28] = 1;
      expect_td(32'h180, s, "R11 mark on emptied queue");
    end
    start(32'h180);
    while (!tx_req) @(negedge clk);
    teardown_req = 1'b1;
    @(negedge clk); teardown_req = 1'b0;
    wait_idle();
    chk(exp_wa.size() == 0 && exp_tb.size() == 0, "R11 queue drained",
        32'(exp_wa.size() + exp_tb.size()), 32'h0);
    chk(busy == 0 && mem_req == 0, "R1 idle at end", {30'h0, busy, mem_req}, 32'h0);

    finish_run();
  end
endmodule